// File: doc/BRIEF.md
# Load Effective Address Unit

This block resolves the operand of a load instruction under seven addressing modes. A request is started with a one-cycle `start` strobe. It carries a 3-bit mode code, a signed constant field from the instruction, the value of the base register and the address of the current instruction. The unit forms the effective address and makes the reads the mode needs on a synchronous word-addressed data memory port. That is zero, one or two reads. It then returns the loaded value and the effective address with a one-cycle `done` pulse.

The constant is sign-extended to the data width, and all address arithmetic wraps modulo 2^16. PC-relative addresses are taken from the next-instruction address, which is the current address plus one. The post-increment mode also reports the incremented base value, together with a write-back strobe, so the register file can update the base. The memory returns read data one cycle after `memRdEn`. A request that arrives while another is being served is dropped.

Top module: `load_ea_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `done`, `memRdEn`, `baseWrEn` and `modeErr` are low, and `result`, `effAddr` and `baseNext` are zero.
- R2: Mode 000 (immediate) returns the sign-extended constant as `result` and 0 as `effAddr`. It makes no memory read, and `done` is high in the first cycle after the edge that accepts `start`.
- R3: Mode 001 (direct) makes one read at the sign-extended constant. That address is reported as `effAddr` and the word read is reported as `result`. `done` is high in the third cycle after the accepting edge.
- R4: Mode 010 (register indirect) makes one read at the base value, with the same result, address reporting and timing as R3.
- R5: Mode 011 (post-increment) reads at the base value with the timing of R3. `baseWrEn` is high with `done`, and `baseNext` equals the base plus one, modulo 2^16. No other mode raises `baseWrEn`.
- R6: Mode 100 (indexed) reads at the base plus the sign-extended constant, modulo 2^16. A constant of 500 with a base of 25 gives 525, and negative constants count down.
- R7: Mode 101 (PC-relative) reads at the current instruction address plus one plus the sign-extended constant. An instruction at 200 with a constant of 30 gives 231.
- R8: Mode 110 (memory indirect) first reads at the sign-extended constant. It then reads at the word returned, and reports that word as `effAddr` and the second word read as `result`. `done` is high in the fifth cycle after the accepting edge.
- R9: Mode 111 is reserved. It makes no read and raises `modeErr` together with `done` one cycle after acceptance, with `result` and `effAddr` at zero.
- R10: A `start` seen while a request is in progress has no effect. The running request completes with its own values, and no further request follows it.
- R11: `memRdEn` is high for a single cycle per read, never in two consecutive cycles and never in a cycle where `done` is high.
- R12: `result`, `effAddr` and `baseNext` change only at the edge that raises `done`, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| mode | input | 3 | Addressing mode code |
| constIn | input | CONST_W (12) | Signed constant from the instruction |
| baseVal | input | DATA_W (16) | Base register value |
| pcVal | input | DATA_W (16) | Address of the current instruction |
| memRdEn | output | 1 | Memory read strobe |
| memAddr | output | DATA_W (16) | Memory read word address |
| memRdData | input | DATA_W (16) | Read data, valid one cycle after `memRdEn` |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W (16) | Operand value |
| effAddr | output | DATA_W (16) | Effective address |
| baseWrEn | output | 1 | Base write-back strobe (post-increment) |
| baseNext | output | DATA_W (16) | Incremented base value |
| modeErr | output | 1 | Reserved-mode flag, valid with `done` |

## Verification
The bound checker watches these protocol properties on every cycle:
- reads are spaced apart and never overlap `done`;
- the write-back strobe comes with `done` and carries the effective address plus one;
- the reserved-mode flag comes with `done` and zero outputs;
- the outputs stay unchanged between completions.

Only the bench scenarios can show which address each mode reads and how many cycles each mode takes. The same holds for the two-step pointer chase of the indirect mode, wrap-around at the ends of the address space, and that a `start` during a running request is dropped.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [2:0] {
    AM_IMM      = 3'b000,
    AM_DIR      = 3'b001,
    AM_REGIND   = 3'b010,
    AM_POSTINC  = 3'b011,
    AM_INDEXED  = 3'b100,
    AM_PCREL    = 3'b101,
    AM_INDIRECT = 3'b110,
    AM_RSVD     = 3'b111
  } addr_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_GET1 = 3'd2,
    ST_RD2  = 3'd3,
    ST_GET2 = 3'd4
  } eau_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch request, load first address
    logic rdEn;      // drive a memory read this cycle
    logic ptrLoad;   // replace address with returned pointer word
    logic finMem;    // complete with memory data
    logic finNoMem;  // complete without any read
  } eau_strobe_t;

endpackage

// File: rtl/eau_agen.sv
module eau_agen
  import eau_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PC_STEP = 1
) (
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] constExt,
  input  logic [DATA_W-1:0] baseVal,
  input  logic [DATA_W-1:0] pcVal,
  output logic [DATA_W-1:0] firstAddr
);

  localparam logic [DATA_W-1:0] PcStep = DATA_W'(PC_STEP);

  logic [DATA_W-1:0] nextPc;

  assign nextPc = pcVal + PcStep;

  always_comb begin
    unique case (addr_mode_e'(mode))
      AM_DIR, AM_INDIRECT:    firstAddr = constExt;
      AM_REGIND, AM_POSTINC:  firstAddr = baseVal;
      AM_INDEXED:             firstAddr = baseVal + constExt;
      AM_PCREL:               firstAddr = nextPc + constExt;
      default:                firstAddr = '0;
    endcase
  end

endmodule

// File: rtl/eau_ctrl.sv
module eau_ctrl
  import eau_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  mode,
  output eau_strobe_t strb
);

  eau_state_e state, stateNext;
  logic       twoReads;
  logic       noRead;

  assign noRead = (addr_mode_e'(mode) == AM_IMM) || (addr_mode_e'(mode) == AM_RSVD);

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.capture = 1'b1;
          if (noRead) strb.finNoMem = 1'b1;
          else        stateNext     = ST_RD1;
        end
      end
      ST_RD1: begin
        strb.rdEn = 1'b1;
        stateNext = ST_GET1;
      end
      ST_GET1: begin
        if (twoReads) begin
          strb.ptrLoad = 1'b1;
          stateNext    = ST_RD2;
        end else begin
          strb.finMem = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      ST_RD2: begin
        strb.rdEn = 1'b1;
        stateNext = ST_GET2;
      end
      ST_GET2: begin
        strb.finMem = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      twoReads <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.capture) twoReads <= (addr_mode_e'(mode) == AM_INDIRECT);
    end
  end

endmodule

// File: rtl/eau_dpath.sv
module eau_dpath
  import eau_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CONST_W = 12,
  parameter int PC_STEP = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  eau_strobe_t        strb,
  input  logic [2:0]         mode,
  input  logic [CONST_W-1:0] constIn,
  input  logic [DATA_W-1:0]  baseVal,
  input  logic [DATA_W-1:0]  pcVal,
  input  logic [DATA_W-1:0]  memRdData,
  output logic [DATA_W-1:0]  memAddr,
  output logic               done,
  output logic [DATA_W-1:0]  result,
  output logic [DATA_W-1:0]  effAddr,
  output logic               baseWrEn,
  output logic [DATA_W-1:0]  baseNext,
  output logic               modeErr
);

  localparam int EXT_W = DATA_W - CONST_W;

  logic [DATA_W-1:0] constExt;
  logic [DATA_W-1:0] firstAddr;
  logic [DATA_W-1:0] eaR;
  logic [DATA_W-1:0] baseR;
  logic [2:0]        modeR;
  logic              isPostInc;

  generate
    if (EXT_W > 0) begin : g_sext
      assign constExt = {{EXT_W{constIn[CONST_W-1]}}, constIn};
    end else begin : g_full
      assign constExt = constIn[DATA_W-1:0];
    end
  endgenerate

  eau_agen #(
    .DATA_W (DATA_W),
    .PC_STEP(PC_STEP)
  ) u_agen (
    .mode     (mode),
    .constExt (constExt),
    .baseVal  (baseVal),
    .pcVal    (pcVal),
    .firstAddr(firstAddr)
  );

  assign memAddr   = eaR;
  assign isPostInc = (addr_mode_e'(modeR) == AM_POSTINC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaR      <= '0;
      baseR    <= '0;
      modeR    <= '0;
      done     <= 1'b0;
      result   <= '0;
      effAddr  <= '0;
      baseWrEn <= 1'b0;
      baseNext <= '0;
      modeErr  <= 1'b0;
    end else begin
      done     <= strb.finMem | strb.finNoMem;
      baseWrEn <= strb.finMem & isPostInc;
      modeErr  <= strb.finNoMem & (addr_mode_e'(mode) == AM_RSVD);
      if (strb.capture) begin
        eaR   <= firstAddr;
        baseR <= baseVal;
        modeR <= mode;
      end
      if (strb.ptrLoad) eaR <= memRdData;
      if (strb.finMem) begin
        result  <= memRdData;
        effAddr <= eaR;
        if (isPostInc) baseNext <= baseR + DATA_W'(1);
      end
      if (strb.finNoMem) begin
        result  <= (addr_mode_e'(mode) == AM_IMM) ? constExt : '0;
        effAddr <= '0;
      end
    end
  end

endmodule

// File: rtl/load_ea_unit.sv
module load_ea_unit
  import eau_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CONST_W = 12,
  parameter int PC_STEP = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [2:0]         mode,
  input  logic [CONST_W-1:0] constIn,
  input  logic [DATA_W-1:0]  baseVal,
  input  logic [DATA_W-1:0]  pcVal,
  output logic               memRdEn,
  output logic [DATA_W-1:0]  memAddr,
  input  logic [DATA_W-1:0]  memRdData,
  output logic               done,
  output logic [DATA_W-1:0]  result,
  output logic [DATA_W-1:0]  effAddr,
  output logic               baseWrEn,
  output logic [DATA_W-1:0]  baseNext,
  output logic               modeErr
);

  eau_strobe_t strb;

  eau_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .mode (mode),
    .strb (strb)
  );

  eau_dpath #(
    .DATA_W (DATA_W),
    .CONST_W(CONST_W),
    .PC_STEP(PC_STEP)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .mode     (mode),
    .constIn  (constIn),
    .baseVal  (baseVal),
    .pcVal    (pcVal),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .done     (done),
    .result   (result),
    .effAddr  (effAddr),
    .baseWrEn (baseWrEn),
    .baseNext (baseNext),
    .modeErr  (modeErr)
  );

  assign memRdEn = strb.rdEn;

endmodule

// File: rtl/eau_chk.sv
module eau_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdEn,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] effAddr,
  input logic              baseWrEn,
  input logic [DATA_W-1:0] baseNext,
  input logic              modeErr
);

  // R11
  read_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R11
  read_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> !done);

  // R5
  postinc_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |-> (done && !modeErr && baseNext == DATA_W'(effAddr + DATA_W'(1))));

  // R9
  rsvd_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> (done && !baseWrEn && result == '0 && effAddr == '0));

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(result) && $stable(effAddr) && $stable(baseNext)));

endmodule

bind load_ea_unit eau_chk #(.DATA_W(DATA_W)) u_eau_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memRdEn (memRdEn),
  .done    (done),
  .result  (result),
  .effAddr (effAddr),
  .baseWrEn(baseWrEn),
  .baseNext(baseNext),
  .modeErr (modeErr)
);

// File: tb/test_load_ea_unit.sv
module test_load_ea_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [2:0]  mode;
  logic [11:0] constIn;
  logic [15:0] baseVal;
  logic [15:0] pcVal;
  logic        memRdEn;
  logic [15:0] memAddr;
  logic [15:0] memRdData;
  logic        done;
  logic [15:0] result;
  logic [15:0] effAddr;
  logic        baseWrEn;
  logic [15:0] baseNext;
  logic        modeErr;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  load_ea_unit i_load_ea_unit (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .constIn(constIn),
    .baseVal(baseVal), .pcVal(pcVal), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .done(done), .result(result), .effAddr(effAddr),
    .baseWrEn(baseWrEn), .baseNext(baseNext), .modeErr(modeErr)
  );

  // memory content as a function of the address
  function automatic logic [15:0] memFn(input logic [15:0] a);
    return (a ^ 16'h5A5A) + 16'd7;
  endfunction

  always_ff @(posedge clk) begin
    if (memRdEn) memRdData <= memFn(memAddr);
  end

  function automatic logic [15:0] sx(input logic [11:0] c);
    return {{4{c[11]}}, c};
  endfunction

  function automatic string reqOf(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  m;
    logic [11:0] c;
    logic [15:0] b;
    logic [15:0] p;
    logic [15:0] ea;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 12'h07B, 16'h0000, 16'h0000, 16'h0000},  // immediate positive
    '{3'd0, 12'hFF6, 16'h0000, 16'h0000, 16'h0000},  // immediate negative
    '{3'd1, 12'h040, 16'h0000, 16'h0000, 16'h0040},  // direct
    '{3'd1, 12'hF00, 16'h0000, 16'h0000, 16'hFF00},  // direct, sign extended
    '{3'd2, 12'h000, 16'h1234, 16'h0000, 16'h1234},  // register indirect
    '{3'd3, 12'h000, 16'h00FF, 16'h0000, 16'h00FF},  // post-increment
    '{3'd3, 12'h000, 16'hFFFF, 16'h0000, 16'hFFFF},  // post-increment wrap
    '{3'd4, 12'h1F4, 16'h0019, 16'h0000, 16'h020D},  // indexed 500+25
    '{3'd4, 12'hFFC, 16'h0002, 16'h0000, 16'hFFFE},  // indexed negative wrap
    '{3'd5, 12'h01E, 16'h0000, 16'h00C8, 16'h00E7},  // pc-relative 200,+30
    '{3'd5, 12'hFEF, 16'h0000, 16'h0010, 16'h0000},  // pc-relative backwards
    '{3'd6, 12'h021, 16'h0000, 16'h0000, 16'h5A82},  // memory indirect
    '{3'd7, 12'h055, 16'h4444, 16'h0000, 16'h0000}   // reserved
  };

  // issue one request, then observe until done; returns observations
  task automatic runReq(input vec_t v, input bit holdStart,
                        output int lat, output int rds, output int consec,
                        output logic [15:0] a1, output logic [15:0] a2,
                        output logic [15:0] rs, output logic [15:0] ea,
                        output logic wb, output logic [15:0] bn,
                        output logic er);
    bit prevRd = 1'b0;
    @(negedge clk);
    mode = v.m; constIn = v.c; baseVal = v.b; pcVal = v.p; start = 1'b1;
    lat = 0; rds = 0; consec = 0; a1 = 'x; a2 = 'x;
    rs = 'x; ea = 'x; wb = 1'b0; bn = 'x; er = 1'b0;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      if (holdStart && n < 4) begin
        start = 1'b1; mode = 3'd0; constIn = 12'h3AA; baseVal = 16'h7777;
      end else begin
        start = 1'b0;
      end
      if (memRdEn) begin
        if (prevRd) consec++;
        if (rds == 0) a1 = memAddr; else a2 = memAddr;
        rds++;
      end
      prevRd = memRdEn;
      if (done) begin
        lat = n; rs = result; ea = effAddr; wb = baseWrEn; bn = baseNext;
        er = modeErr;
        break;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #400000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int lat, rds, consec;
    logic [15:0] a1, a2, rs, ea, bn;
    logic wb, er;
    string rq;
    int latExp, rdExp;
    logic [15:0] rsExp, a1Exp;

    rstN = 1'b0; start = 1'b0; mode = '0; constIn = '0; baseVal = '0; pcVal = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done", {15'b0, done}, 16'h0);
    chk("R1", "memRdEn", {15'b0, memRdEn}, 16'h0);
    chk("R1", "baseWrEn", {15'b0, baseWrEn}, 16'h0);
    chk("R1", "modeErr", {15'b0, modeErr}, 16'h0);
    chk("R1", "result", result, 16'h0);
    chk("R1", "effAddr", effAddr, 16'h0);
    chk("R1", "baseNext", baseNext, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "done after release", {15'b0, done}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      rq = reqOf(v.m);
      runReq(v, 1'b0, lat, rds, consec, a1, a2, rs, ea, wb, bn, er);
      case (v.m)
        3'd0, 3'd7: begin latExp = 1; rdExp = 0; end
        3'd6:       begin latExp = 5; rdExp = 2; end
        default:    begin latExp = 3; rdExp = 1; end
      endcase
      if (v.m == 3'd0)      rsExp = sx(v.c);
      else if (v.m == 3'd7) rsExp = 16'h0;
      else if (v.m == 3'd6) rsExp = memFn(memFn(sx(v.c)));
      else                  rsExp = memFn(v.ea);
      a1Exp = (v.m == 3'd6) ? sx(v.c) : v.ea;
      chk(rq, "latency", 16'(lat), 16'(latExp));
      chk(rq, "read count", 16'(rds), 16'(rdExp));
      chk("R11", "consecutive reads", 16'(consec), 16'h0);
      chk(rq, "result", rs, rsExp);
      chk(rq, "effAddr", ea, v.ea);
      if (rdExp > 0) chk(rq, "first read address", a1, a1Exp);
      if (rdExp > 1) chk("R8", "second read address", a2, memFn(sx(v.c)));
      chk("R5", "baseWrEn", {15'b0, wb}, {15'b0, (v.m == 3'd3)});
      if (v.m == 3'd3) chk("R5", "baseNext", bn, v.b + 16'd1);
      chk("R9", "modeErr", {15'b0, er}, {15'b0, (v.m == 3'd7)});
      @(negedge clk);
      chk("R12", "done one cycle", {15'b0, done}, 16'h0);
      chk("R12", "result held", result, rsExp);
    end

    // R10: start held high while an indirect request runs
    begin
      vec_t v = '{3'd6, 12'h1C0, 16'h0000, 16'h0000, 16'h0000};
      runReq(v, 1'b1, lat, rds, consec, a1, a2, rs, ea, wb, bn, er);
      chk("R10", "latency while start held", 16'(lat), 16'd5);
      chk("R10", "result unaffected", rs, memFn(memFn(16'h01C0)));
      chk("R10", "effAddr unaffected", ea, memFn(16'h01C0));
      chk("R10", "reads", 16'(rds), 16'd2);
      repeat (2) begin
        @(negedge clk);
        chk("R10", "no queued request done", {15'b0, done}, 16'h0);
        chk("R10", "no queued request read", {15'b0, memRdEn}, 16'h0);
      end
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule